// File: doc/BRIEF.md
# Ripple-Carry Arithmetic Logic Unit with Signed Compare

This block is a purely combinational integer ALU made from a row of identical one-bit slices. A carry ripples from the least significant slice to the most significant one. Each slice can invert its A bit and its B bit, and then chooses between AND, OR, the full-adder sum, or a "less" input. The slice in the top position is a separate variant. It compares the carry entering the sign bit with the carry leaving it to detect signed overflow. It also produces the compare bit, which is fed back into the less input of slice 0.

A 4-bit control word selects the function. Bit 3 inverts A. Bit 2 inverts B and also serves as the carry into slice 0, so a single line turns an add into a two's-complement subtract. Bits 1:0 choose the slice output. Beside the result, the block drives a zero flag that an equality branch can use, a signed overflow flag and the final carry.

Top module: `ripple_alu`

## Requirements
- R1: Control 4'b0000 gives the bitwise AND of A and B.
- R2: Control 4'b0001 gives the bitwise OR of A and B.
- R3: Control 4'b0010 gives A + B modulo 2^32 on the result, and the carry output equals bit 32 of the unsigned sum.
- R4: Control 4'b0110 gives A - B modulo 2^32, computed as A + ~B + 1. The carry output is 1 exactly when A >= B as unsigned numbers.
- R5: For add and subtract, the overflow output is 1 exactly when the signed result is wrong. For an add, that means both operands have the same sign and the result has the other sign, so two negatives that produce a carry without a sign change give 0. For a subtract, it means the operand signs differ and the result sign differs from A.
- R6: For AND, OR, NOR and set-less-than, the overflow and carry outputs are both 0.
- R7: Control 4'b0111 sets result bit 0 to 1 exactly when A < B as signed two's-complement numbers. This holds even when A - B overflows: the bit is the sign of the difference XOR the overflow.
- R8: For set-less-than, result bits 31 down to 1 are 0.
- R9: Control 4'b1100 gives the bitwise NOR of A and B.
- R10: The zero output is 1 exactly when all 32 result bits are 0, for every operation. For a subtract, this means it is 1 exactly when A equals B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| ctrl_i | input | 4 | Function select: [3] invert A, [2] invert B and carry in, [1:0] slice output select |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | High when the result is all zeros |
| ovf_o | output | 1 | Signed overflow, add and subtract only |
| cout_o | output | 1 | Carry out of the top slice, add and subtract only |

## Verification
The assertions state behaviour only for the six defined control words. They assume that operands and control are stable while the combinational outputs are examined, because immediate checks evaluate the settled values. The stimulus uses only those six encodings. It changes the inputs once per cycle on the falling edge, so each vector has half a cycle to settle before the rising-edge comparison. The operand mix covers the sign-boundary values (most positive, most negative, zero, minus one), equal operands, small values and random words. This exercises the overflow cases and the compare correction.

// File: rtl/ralu_pkg.sv
package ralu_pkg;

    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } sel_e;

    localparam logic [3:0] CTL_AND = 4'b0000;
    localparam logic [3:0] CTL_OR  = 4'b0001;
    localparam logic [3:0] CTL_ADD = 4'b0010;
    localparam logic [3:0] CTL_SUB = 4'b0110;
    localparam logic [3:0] CTL_SLT = 4'b0111;
    localparam logic [3:0] CTL_NOR = 4'b1100;

    typedef struct packed {
        logic ainv;
        logic bneg;
        sel_e sel;
    } ctl_t;

    typedef struct packed {
        logic sum;
        logic cout;
    } fa_t;

    // parity for the sum, majority for the carry
    function automatic fa_t full_add(input logic x, input logic y, input logic cin);
        fa_t r;
        r.sum  = x ^ y ^ cin;
        r.cout = (x & y) | (x & cin) | (y & cin);
        return r;
    endfunction

    function automatic logic pick_out(input logic x, input logic y, input logic sum,
                                      input logic less, input sel_e sel);
        logic r;
        unique case (sel)
            SEL_AND:  r = x & y;
            SEL_OR:   r = x | y;
            SEL_SUM:  r = sum;
            default:  r = less;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ralu_slice.sv
module ralu_slice
    import ralu_pkg::*;
(
    input  logic a_i,
    input  logic b_i,
    input  logic ainv_i,
    input  logic bneg_i,
    input  logic cin_i,
    input  logic less_i,
    input  sel_e sel_i,
    output logic res_o,
    output logic cout_o
);

    typedef struct packed {
        logic x;
        logic y;
        fa_t  fa;
        logic res;
    } slice_t;

    slice_t slice_d;

    always_comb begin
        slice_d     = '0;
        slice_d.x   = a_i ^ ainv_i;
        slice_d.y   = b_i ^ bneg_i;
        slice_d.fa  = full_add(slice_d.x, slice_d.y, cin_i);
        slice_d.res = pick_out(slice_d.x, slice_d.y, slice_d.fa.sum, less_i, sel_i);
    end

    assign res_o  = slice_d.res;
    assign cout_o = slice_d.fa.cout;

endmodule

// File: rtl/ralu_msb_slice.sv
module ralu_msb_slice
    import ralu_pkg::*;
(
    input  logic a_i,
    input  logic b_i,
    input  logic ainv_i,
    input  logic bneg_i,
    input  logic cin_i,
    input  sel_e sel_i,
    output logic res_o,
    output logic cout_o,
    output logic ovf_o,
    output logic set_o
);

    typedef struct packed {
        logic x;
        logic y;
        fa_t  fa;
        logic ovf;
        logic set;
        logic res;
    } msb_t;

    msb_t msb_d;

    always_comb begin
        msb_d     = '0;
        msb_d.x   = a_i ^ ainv_i;
        msb_d.y   = b_i ^ bneg_i;
        msb_d.fa  = full_add(msb_d.x, msb_d.y, cin_i);
        // carry into and out of the sign position disagree only on overflow
        msb_d.ovf = cin_i ^ msb_d.fa.cout;
        // the sign of the difference is flipped when the difference overflowed
        msb_d.set = msb_d.fa.sum ^ msb_d.ovf;
        msb_d.res = pick_out(msb_d.x, msb_d.y, msb_d.fa.sum, 1'b0, sel_i);
    end

    assign res_o  = msb_d.res;
    assign cout_o = msb_d.fa.cout;
    assign ovf_o  = msb_d.ovf;
    assign set_o  = msb_d.set;

endmodule

// File: rtl/ralu_zero.sv
module ralu_zero #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] res_i,
    output logic             zero_o
);

    assign zero_o = ~(|res_i);

endmodule

// File: rtl/ripple_alu.sv
module ripple_alu
    import ralu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [3:0]       ctrl_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o,
    output logic             ovf_o,
    output logic             cout_o
);

    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic ovf;
        logic cout;
    } flags_t;

    ctl_t             ctl_d;
    flags_t           flags_d;
    logic [WIDTH:0]   carry_w;
    logic [WIDTH-1:0] res_w;
    logic             set_w;
    logic             msb_ovf_w;

    always_comb begin
        ctl_d.ainv = ctrl_i[3];
        ctl_d.bneg = ctrl_i[2];
        ctl_d.sel  = sel_e'(ctrl_i[1:0]);
    end

    // inverting B and injecting a carry of one form the two's-complement negate
    assign carry_w[0] = ctl_d.bneg;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == MSB) begin : g_top
            ralu_msb_slice u_slice (
                .a_i    (a_i[i]),
                .b_i    (b_i[i]),
                .ainv_i (ctl_d.ainv),
                .bneg_i (ctl_d.bneg),
                .cin_i  (carry_w[i]),
                .sel_i  (ctl_d.sel),
                .res_o  (res_w[i]),
                .cout_o (carry_w[i+1]),
                .ovf_o  (msb_ovf_w),
                .set_o  (set_w)
            );
        end else begin : g_low
            ralu_slice u_slice (
                .a_i    (a_i[i]),
                .b_i    (b_i[i]),
                .ainv_i (ctl_d.ainv),
                .bneg_i (ctl_d.bneg),
                .cin_i  (carry_w[i]),
                .less_i ((i == 0) ? set_w : 1'b0),
                .sel_i  (ctl_d.sel),
                .res_o  (res_w[i]),
                .cout_o (carry_w[i+1])
            );
        end
    end

    always_comb begin
        flags_d = '0;
        if (ctl_d.sel == SEL_SUM) begin
            flags_d.ovf  = msb_ovf_w;
            flags_d.cout = carry_w[WIDTH];
        end
    end

    ralu_zero #(.WIDTH(WIDTH)) u_zero (
        .res_i  (res_w),
        .zero_o (zero_o)
    );

    assign result_o = res_w;
    assign ovf_o    = flags_d.ovf;
    assign cout_o   = flags_d.cout;

endmodule

// File: rtl/ralu_checker.sv
module ralu_checker
    import ralu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [3:0]       ctrl_i,
    input logic [WIDTH-1:0] result_o,
    input logic             zero_o,
    input logic             ovf_o,
    input logic             cout_o
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0]   wide_sum;
    logic [WIDTH-1:0] diff;
    logic             is_arith;

    assign wide_sum = {1'b0, a_i} + {1'b0, b_i};
    assign diff     = a_i - b_i;
    assign is_arith = (ctrl_i == CTL_ADD) || (ctrl_i == CTL_SUB);

    always_comb begin
        if (ctrl_i == CTL_AND) begin
            AST_AND_BITS: assert (result_o == (a_i & b_i)); // R1
        end
        if (ctrl_i == CTL_OR) begin
            AST_OR_BITS: assert (result_o == (a_i | b_i)); // R2
        end
        if (ctrl_i == CTL_ADD) begin
            AST_ADD_SUM: assert ({cout_o, result_o} == wide_sum); // R3
            AST_ADD_OVF: assert (ovf_o == ((a_i[MSB] == b_i[MSB]) && (result_o[MSB] != a_i[MSB]))); // R5
        end
        if (ctrl_i == CTL_SUB) begin
            AST_SUB_DIFF: assert ((result_o == diff) && (cout_o == (a_i >= b_i))); // R4
            AST_SUB_OVF: assert (ovf_o == ((a_i[MSB] != b_i[MSB]) && (result_o[MSB] != a_i[MSB]))); // R5
            AST_SUB_ZERO: assert (zero_o == (a_i == b_i)); // R10
        end
        if ((ctrl_i == CTL_AND) || (ctrl_i == CTL_OR) || (ctrl_i == CTL_NOR) || (ctrl_i == CTL_SLT)) begin
            AST_NO_OVERFLOW: assert (!ovf_o && !cout_o); // R6
        end
        if (ctrl_i == CTL_SLT) begin
            AST_SLT_VALUE: assert (result_o[0] == ($signed(a_i) < $signed(b_i))); // R7
            AST_SLT_UPPER: assert (result_o[MSB:1] == '0); // R8
        end
        if (ctrl_i == CTL_NOR) begin
            AST_NOR_BITS: assert (result_o == ~(a_i | b_i)); // R9
        end
        if (!is_arith && (result_o != '0)) begin
            AST_ZERO_CLEAR: assert (!zero_o); // R10
        end
    end

endmodule

bind ripple_alu ralu_checker #(.WIDTH(WIDTH)) u_ralu_checker (
    .a_i      (a_i),
    .b_i      (b_i),
    .ctrl_i   (ctrl_i),
    .result_o (result_o),
    .zero_o   (zero_o),
    .ovf_o    (ovf_o),
    .cout_o   (cout_o)
);

// File: tb/ripple_alu_tb.sv
`timescale 1ns/1ps
module ripple_alu_tb;

    localparam int W = 32;
    localparam logic [3:0] C_AND = 4'b0000;
    localparam logic [3:0] C_OR  = 4'b0001;
    localparam logic [3:0] C_ADD = 4'b0010;
    localparam logic [3:0] C_SUB = 4'b0110;
    localparam logic [3:0] C_SLT = 4'b0111;
    localparam logic [3:0] C_NOR = 4'b1100;

    typedef struct {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [3:0]   ctrl;
        logic [W-1:0] res;
        logic         zero;
        logic         ovf;
        logic         cout;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic [3:0]   ctrl_i = C_AND;
    logic [W-1:0] result_o;
    logic         zero_o;
    logic         ovf_o;
    logic         cout_o;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    ripple_alu u_dut (
        .a_i      (a_i),
        .b_i      (b_i),
        .ctrl_i   (ctrl_i),
        .result_o (result_o),
        .zero_o   (zero_o),
        .ovf_o    (ovf_o),
        .cout_o   (cout_o)
    );

    function automatic exp_t model(input logic [W-1:0] a, input logic [W-1:0] b, input logic [3:0] c);
        exp_t e;
        logic [W:0] s;
        e.a = a; e.b = b; e.ctrl = c;
        e.ovf = 1'b0; e.cout = 1'b0; e.res = '0;
        case (c)
            C_AND: e.res = a & b;
            C_OR:  e.res = a | b;
            C_NOR: e.res = ~(a | b);
            C_ADD: begin
                s = {1'b0, a} + {1'b0, b};
                e.res = s[W-1:0];
                e.cout = s[W];
                e.ovf = (a[W-1] == b[W-1]) && (e.res[W-1] != a[W-1]);
            end
            C_SUB: begin
                e.res = a - b;
                e.cout = (a >= b);
                e.ovf = (a[W-1] != b[W-1]) && (e.res[W-1] != a[W-1]);
            end
            default: e.res = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
        endcase
        e.zero = (e.res == '0);
        return e;
    endfunction

    function automatic string op_tag(input logic [3:0] c);
        case (c)
            C_AND: return "R1";
            C_OR:  return "R2";
            C_ADD: return "R3";
            C_SUB: return "R4";
            C_NOR: return "R9";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input string what, input logic [W-1:0] act,
                         input logic [W-1:0] exp, input exp_t e);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s ctrl=%b a=%h b=%h actual=%h expected=%h",
                     tag, what, e.ctrl, e.a, e.b, act, exp);
        end
    endtask

    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic [3:0] c);
        @(negedge clk);
        a_i = a;
        b_i = b;
        ctrl_i = c;
        sb_q.push_back(model(a, b, c));
    endtask

    // monitor: compares one queued item per rising edge
    always @(posedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            exp_t e;
            bit arith;
            e = sb_q.pop_front();
            arith = (e.ctrl == C_ADD) || (e.ctrl == C_SUB);
            if (e.ctrl == C_SLT) begin
                check("R7", "slt bit0", {{(W-1){1'b0}}, result_o[0]}, {{(W-1){1'b0}}, e.res[0]}, e);
                check("R8", "slt upper", {1'b0, result_o[W-1:1]}, {1'b0, e.res[W-1:1]}, e);
            end else begin
                check(op_tag(e.ctrl), "result", result_o, e.res, e);
            end
            check("R10", "zero", {{(W-1){1'b0}}, zero_o}, {{(W-1){1'b0}}, e.zero}, e);
            check(arith ? "R5" : "R6", "overflow", {{(W-1){1'b0}}, ovf_o}, {{(W-1){1'b0}}, e.ovf}, e);
            check(arith ? op_tag(e.ctrl) : "R6", "carry", {{(W-1){1'b0}}, cout_o}, {{(W-1){1'b0}}, e.cout}, e);
        end
    end

    function automatic logic [W-1:0] edge_val(input int k);
        case (k % 6)
            0: return 32'h7FFF_FFFF;
            1: return 32'h8000_0000;
            2: return 32'h0000_0000;
            3: return 32'hFFFF_FFFF;
            4: return 32'h0000_0001;
            default: return 32'h8000_0001;
        endcase
    endfunction

    function automatic logic [3:0] op_at(input int k);
        case (k % 6)
            0: return C_AND;
            1: return C_OR;
            2: return C_ADD;
            3: return C_SUB;
            4: return C_SLT;
            default: return C_NOR;
        endcase
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // reset-state vector: all-zero inputs under AND
        drive('0, '0, C_AND);
        // R5: most positive plus one overflows
        drive(32'h7FFF_FFFF, 32'h0000_0001, C_ADD);
        // R5: two negatives carry out but do not overflow
        drive(32'hFFFF_FFFF, 32'hFFFF_FFFE, C_ADD);
        // R5: two most-negative values overflow with carry
        drive(32'h8000_0000, 32'h8000_0000, C_ADD);
        // R4 and R10: equal operands subtract to zero with carry
        drive(32'h1234_5678, 32'h1234_5678, C_SUB);
        // R5: most negative minus one overflows
        drive(32'h8000_0000, 32'h0000_0001, C_SUB);
        // R7: compare where the difference overflows
        drive(32'h7FFF_FFFF, 32'h8000_0000, C_SLT);
        drive(32'h8000_0000, 32'h7FFF_FFFF, C_SLT);
        drive(32'h8000_0000, 32'h0000_0001, C_SLT);
        drive(32'hFFFF_FFFF, 32'h0000_0000, C_SLT);
        drive(32'h0000_0005, 32'h0000_0005, C_SLT);
        // R9 and R10: NOR of all ones yields zero
        drive(32'hFFFF_FFFF, 32'h0000_0000, C_NOR);
        drive(32'h0000_0000, 32'h0000_0000, C_NOR);
        drive(32'hF0F0_0F0F, 32'h0FF0_F00F, C_AND);
        drive(32'hF0F0_0F0F, 32'h0FF0_F00F, C_OR);
        for (int k = 0; k < 36; k++) begin
            drive(edge_val(k), edge_val(k / 6), op_at(k / 6));
        end
        for (int k = 0; k < 600; k++) begin
            logic [W-1:0] a;
            logic [W-1:0] b;
            a = $urandom();
            b = $urandom();
            case (k % 4)
                1: b = a;
                2: begin a = edge_val(k); b = $urandom() & 32'h0000_00FF; end
                3: begin a = a & 32'h0000_000F; b = b & 32'h0000_000F; end
                default: ;
            endcase
            drive(a, b, op_at(k));
        end
        while (sb_q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule